// File: doc/BRIEF.md
# Two-Level Nanocoded Control Sequencer

This block steps through a micro-program and produces one wide datapath control word per clock. Control words are stored in two levels. A narrow micro-store holds 17-bit steps. Each step is one of two things: a branch that redirects the micro-program counter, or a short pointer into a separate nano-store. The nano-store holds the 68-bit control patterns. A pattern that several steps need is kept in the nano-store only once, and each of those steps points to it.

Both stores are RAM. A host loads them through two write ports while the sequencer is idle. A strobed dispatch address starts a routine. Two condition flags steer conditional branches. An end-of-routine step raises `done` for one cycle and returns the sequencer to idle.

Top module: `nanoseq_top`

## Requirements
- R1: After a synchronous active-low reset, and whenever the sequencer is idle, `ctrl_word` is all zeros and `done` is low. The sequencer leaves reset idle.
- R2: While idle, `disp_valid` high loads `disp_addr` into the micro-program counter at the next clock, and execution starts there. While running, `disp_valid` is ignored.
- R3: A micro-word with bit 16 = 0 is a pointer step. During that cycle `ctrl_word` equals the nano-store word addressed by bits 8:0, and the micro-program counter then advances by one.
- R4: A micro-word with bit 16 = 1 is a branch. Bits 15:14 give the condition: 00 = always, 01 = flag0 set (`flags[0]`), 10 = flag1 set (`flags[1]`). Bits 9:0 give the target. During a branch cycle `ctrl_word` is zero. A taken branch loads the target, and a branch that is not taken advances by one.
- R5: A branch word with condition 11 ends the routine. In that cycle `done` is high and `ctrl_word` is zero. Afterwards the sequencer stays idle, with `done` low, until the next dispatch.
- R6: Two steps that point to the same nano entry present the same 68-bit pattern.
- R7: Writes to either store take effect only while the sequencer is idle. A write strobed during execution leaves the store unchanged.
- R8: All 68 bits of a nano word, including bit 0 and bit 67, appear on `ctrl_word`.
- R9: Advancing from the highest micro address wraps the counter to address 0.
- R10: Store contents can be replaced after reset, and a later run uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch strobe |
| disp_addr | input | UADDR_W (10) | Routine start address |
| flags | input | 2 | Condition flags tested by branches |
| uwr_en | input | 1 | Micro-store write strobe |
| uwr_addr | input | UADDR_W (10) | Micro-store write address |
| uwr_data | input | UWORD_W (17) | Micro-store write data |
| nwr_en | input | 1 | Nano-store write strobe |
| nwr_addr | input | NPTR_W (9) | Nano-store write address |
| nwr_data | input | NWORD_W (68) | Nano-store write data |
| ctrl_word | output | NWORD_W (68) | Current control word |
| done | output | 1 | One-cycle end-of-routine pulse |

## Verification
The bench builds the block with its default parameters: 17-bit micro-words, 10-bit micro addresses (1024 steps), 9-bit nano pointers (512 entries) and 68-bit control words. These values put the top micro address 0x3FF within reach, so the counter wrap can be driven directly. They also make the last nano entry and both edge bits of the wide word observable. Routines are laid out so that one nano entry is shared by two steps. One conditional branch sees the other flag set, which shows that each condition tests only its own flag.

// File: rtl/nanoseq_pkg.sv
// Package: shared types for the nanocoded sequencer.
// Assumes the micro-word format bit is the MSB and the two condition bits sit directly below it.
package nanoseq_pkg;

    // Branch condition codes carried in a branch-format micro-word
    typedef enum logic [1:0] {
        COND_ALWAYS = 2'b00,
        COND_FLAG0  = 2'b01,
        COND_FLAG1  = 2'b10,
        COND_END    = 2'b11
    } cond_e;

    // Sequencer run state
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    localparam int FLAG_W = 2;

endpackage

// File: rtl/nanoseq_wcs.sv
// Module: writable control store.
// One synchronous write port and one combinational read port.
// Contents are not reset; the host must load them before use.
module nanoseq_wcs #(
    parameter int W  = 17,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Store the write data at the rising edge when strobed
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nanoseq_udecode.sv
// Module: micro-word decoder.
// Splits a micro-word into a nano pointer or a branch, and resolves the branch condition.
// All outputs are quiet while `active` is low.
module nanoseq_udecode
    import nanoseq_pkg::*;
#(
    parameter int UWORD_W = 17,
    parameter int UADDR_W = 10,
    parameter int NPTR_W  = 9
) (
    input  logic               active,
    input  logic [UWORD_W-1:0] uword,
    input  logic [FLAG_W-1:0]  flags,
    output logic               is_nano,
    output logic [NPTR_W-1:0]  nano_ptr,
    output logic               jump_taken,
    output logic [UADDR_W-1:0] jump_target,
    output logic               routine_end
);
    localparam int FMT_BIT = UWORD_W - 1;
    localparam int COND_HI = UWORD_W - 2;
    localparam int COND_LO = UWORD_W - 3;

    cond_e cond;
    logic  unused_bits;

    assign cond        = cond_e'(uword[COND_HI:COND_LO]);
    assign nano_ptr    = uword[NPTR_W-1:0];
    assign jump_target = uword[UADDR_W-1:0];
    assign unused_bits = ^uword[COND_LO-1:UADDR_W];

    // Classify the word and evaluate its condition against the flags
    always_comb begin
        is_nano     = active & ~uword[FMT_BIT];
        jump_taken  = 1'b0;
        routine_end = 1'b0;
        if (active && uword[FMT_BIT]) begin
            unique case (cond)
                COND_ALWAYS: jump_taken  = 1'b1;
                COND_FLAG0:  jump_taken  = flags[0];
                COND_FLAG1:  jump_taken  = flags[1];
                COND_END:    routine_end = 1'b1;
                default:     jump_taken  = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/nanoseq_upc.sv
// Module: micro-program counter and run state.
// Holds the sequencer state. A dispatch is accepted only when idle.
module nanoseq_upc
    import nanoseq_pkg::*;
#(
    parameter int UADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               disp_valid,
    input  logic [UADDR_W-1:0] disp_addr,
    input  logic               jump_taken,
    input  logic [UADDR_W-1:0] jump_target,
    input  logic               routine_end,
    output logic               running,
    output logic [UADDR_W-1:0] upc
);
    seq_state_e         state_q;
    logic [UADDR_W-1:0] upc_q;

    // Advance the counter: dispatch, branch, step or park
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            upc_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (disp_valid) begin
                        upc_q   <= disp_addr;
                        state_q <= SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (routine_end) begin
                        state_q <= SEQ_IDLE;
                    end else if (jump_taken) begin
                        upc_q <= jump_target;
                    end else begin
                        upc_q <= upc_q + UADDR_W'(1);
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign running = (state_q == SEQ_RUN);
    assign upc     = upc_q;
endmodule

// File: rtl/nanoseq_top.sv
// Module: two-level nanocoded control sequencer.
// The micro-store supplies either a branch or a nano pointer. The nano-store supplies the wide control word.
// Host writes pass only while idle. Assumes both stores are loaded before the first dispatch.
module nanoseq_top
    import nanoseq_pkg::*;
#(
    parameter int UWORD_W = 17,
    parameter int UADDR_W = 10,
    parameter int NPTR_W  = 9,
    parameter int NWORD_W = 68
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               disp_valid,
    input  logic [UADDR_W-1:0] disp_addr,
    input  logic [FLAG_W-1:0]  flags,
    input  logic               uwr_en,
    input  logic [UADDR_W-1:0] uwr_addr,
    input  logic [UWORD_W-1:0] uwr_data,
    input  logic               nwr_en,
    input  logic [NPTR_W-1:0]  nwr_addr,
    input  logic [NWORD_W-1:0] nwr_data,
    output logic [NWORD_W-1:0] ctrl_word,
    output logic               done
);
    logic               running;
    logic [UADDR_W-1:0] upc_q;
    logic [UWORD_W-1:0] uword;
    logic [NWORD_W-1:0] nano_rd;
    logic               is_nano;
    logic [NPTR_W-1:0]  nano_ptr;
    logic               jump_taken;
    logic [UADDR_W-1:0] jump_target;
    logic               routine_end;
    logic               uwr_ok;
    logic               nwr_ok;

    // Block host writes while a routine executes
    assign uwr_ok = uwr_en & ~running;
    assign nwr_ok = nwr_en & ~running;

    nanoseq_wcs #(.W(UWORD_W), .AW(UADDR_W)) ustore_i (
        .clk     (clk),
        .wr_en   (uwr_ok),
        .wr_addr (uwr_addr),
        .wr_data (uwr_data),
        .rd_addr (upc_q),
        .rd_data (uword)
    );

    nanoseq_wcs #(.W(NWORD_W), .AW(NPTR_W)) nstore_i (
        .clk     (clk),
        .wr_en   (nwr_ok),
        .wr_addr (nwr_addr),
        .wr_data (nwr_data),
        .rd_addr (nano_ptr),
        .rd_data (nano_rd)
    );

    nanoseq_udecode #(.UWORD_W(UWORD_W), .UADDR_W(UADDR_W), .NPTR_W(NPTR_W)) dec_i (
        .active      (running),
        .uword       (uword),
        .flags       (flags),
        .is_nano     (is_nano),
        .nano_ptr    (nano_ptr),
        .jump_taken  (jump_taken),
        .jump_target (jump_target),
        .routine_end (routine_end)
    );

    nanoseq_upc #(.UADDR_W(UADDR_W)) upc_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .disp_valid  (disp_valid),
        .disp_addr   (disp_addr),
        .jump_taken  (jump_taken),
        .jump_target (jump_target),
        .routine_end (routine_end),
        .running     (running),
        .upc         (upc_q)
    );

    // Drive the nano word on pointer steps and zero otherwise
    assign ctrl_word = is_nano ? nano_rd : '0;
    assign done      = routine_end;
endmodule

// File: rtl/nanoseq_chk.sv
// Module: assertion checker for nanoseq_top, attached by bind.
// Observes the run state, the counter and the current micro-word.
module nanoseq_chk #(
    parameter int UWORD_W = 17,
    parameter int UADDR_W = 10,
    parameter int NWORD_W = 68
) (
    input logic               clk,
    input logic               rst_n,
    input logic               disp_valid,
    input logic [UADDR_W-1:0] disp_addr,
    input logic               running,
    input logic [UADDR_W-1:0] upc,
    input logic [UWORD_W-1:0] uword,
    input logic [NWORD_W-1:0] ctrl_word,
    input logic               done
);
    logic       is_branch;
    logic [1:0] cond_bits;

    assign is_branch = uword[UWORD_W-1];
    assign cond_bits = uword[UWORD_W-2:UWORD_W-3];

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (ctrl_word == '0 && !done));

    p_dispatch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && disp_valid) |=> (running && upc == $past(disp_addr)));

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !is_branch) |=> (running && upc == UADDR_W'($past(upc) + UADDR_W'(1))));

    p_branch_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && is_branch) |-> ctrl_word == '0);

    p_always_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && is_branch && cond_bits == 2'b00) |=> upc == $past(uword[UADDR_W-1:0]));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !running));
endmodule

bind nanoseq_top nanoseq_chk #(
    .UWORD_W (UWORD_W),
    .UADDR_W (UADDR_W),
    .NWORD_W (NWORD_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_addr  (disp_addr),
    .running    (running),
    .upc        (upc_q),
    .uword      (uword),
    .ctrl_word  (ctrl_word),
    .done       (done)
);

// File: tb/nanoseq_top_tb_top.sv
// Bench for nanoseq_top. A vector table of per-step flags and expected outputs is walked by one task.
// Directed tests follow it.
module nanoseq_top_tb_top;
    localparam int UA = 10;
    localparam int NP = 9;
    localparam int NW = 68;
    localparam int UW = 17;
    localparam int NVEC = 23;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          disp_valid;
    logic [UA-1:0] disp_addr;
    logic [1:0]    flags;
    logic          uwr_en;
    logic [UA-1:0] uwr_addr;
    logic [UW-1:0] uwr_data;
    logic          nwr_en;
    logic [NP-1:0] nwr_addr;
    logic [NW-1:0] nwr_data;
    logic [NW-1:0] ctrl_word;
    logic          done;

    int checks   = 0;
    int failures = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    nanoseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_addr(disp_addr),
        .flags(flags), .uwr_en(uwr_en), .uwr_addr(uwr_addr), .uwr_data(uwr_data),
        .nwr_en(nwr_en), .nwr_addr(nwr_addr), .nwr_data(nwr_data),
        .ctrl_word(ctrl_word), .done(done)
    );

    // Vector: [12:11] flags {flag1,flag0}, [10] pointer step, [9:1] nano index, [0] done
    localparam logic [12:0] VEC [NVEC] = '{
        // run A from 0x010: flag0 branch taken, flag1 branch not taken
        {2'b00, 1'b1, 9'd3,   1'b0},  // 0x010 (R6 shared entry 3)
        {2'b00, 1'b1, 9'd5,   1'b0},  // 0x011
        {2'b00, 1'b0, 9'd0,   1'b0},  // 0x012 always -> 0x020
        {2'b00, 1'b1, 9'd3,   1'b0},  // 0x020 (R6 same entry again)
        {2'b01, 1'b0, 9'd0,   1'b0},  // 0x021 flag0 set -> 0x030
        {2'b00, 1'b1, 9'd8,   1'b0},  // 0x030
        {2'b00, 1'b0, 9'd0,   1'b0},  // 0x031 always -> 0x022
        {2'b00, 1'b1, 9'd6,   1'b0},  // 0x022
        {2'b01, 1'b0, 9'd0,   1'b0},  // 0x023 flag1 clear (flag0 set) -> falls through
        {2'b00, 1'b1, 9'd9,   1'b0},  // 0x024
        {2'b00, 1'b0, 9'd0,   1'b1},  // 0x025 end
        // run B from 0x010: flag0 branch not taken, flag1 branch taken
        {2'b00, 1'b1, 9'd3,   1'b0},
        {2'b00, 1'b1, 9'd5,   1'b0},
        {2'b00, 1'b0, 9'd0,   1'b0},
        {2'b00, 1'b1, 9'd3,   1'b0},
        {2'b10, 1'b0, 9'd0,   1'b0},  // 0x021 flag0 clear -> falls through
        {2'b00, 1'b1, 9'd6,   1'b0},  // 0x022
        {2'b10, 1'b0, 9'd0,   1'b0},  // 0x023 flag1 set -> 0x040
        {2'b00, 1'b1, 9'd511, 1'b0},  // 0x040 last nano entry (R8)
        {2'b00, 1'b0, 9'd0,   1'b1},  // 0x041 end
        // run C from 0x3FF: counter wrap (R9)
        {2'b00, 1'b1, 9'd2,   1'b0},  // 0x3FF
        {2'b00, 1'b1, 9'd4,   1'b0},  // 0x000 after wrap
        {2'b00, 1'b0, 9'd0,   1'b1}   // 0x001 end
    };

    function automatic logic [NW-1:0] pat(input int i);
        logic [31:0] a;
        a = 32'(i) * 32'h9E37_79B1 + 32'h1234_5678;
        return {4'(i) ^ 4'hA, a, ~a ^ 32'(i << 3)};
    endfunction

    function automatic logic [UW-1:0] mk_ptr(input int idx);
        return {1'b0, 7'd0, 9'(idx)};
    endfunction

    function automatic logic [UW-1:0] mk_br(input logic [1:0] c, input int tgt);
        return {1'b1, c, 4'd0, 10'(tgt)};
    endfunction

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic check_out(input string req, input logic [NW-1:0] exp_c, input logic exp_d);
        checks++;
        if (ctrl_word !== exp_c) begin
            failures++;
            $display("FAIL %s ctrl_word actual=%h expected=%h", req, ctrl_word, exp_c);
        end
        checks++;
        if (done !== exp_d) begin
            failures++;
            $display("FAIL %s done actual=%b expected=%b", req, done, exp_d);
        end
    endtask

    task automatic wr_micro(input int a, input logic [UW-1:0] d);
        @(negedge clk);
        uwr_en = 1'b1; uwr_addr = UA'(a); uwr_data = d;
        @(negedge clk);
        uwr_en = 1'b0;
    endtask

    task automatic wr_nano(input int a, input logic [NW-1:0] d);
        @(negedge clk);
        nwr_en = 1'b1; nwr_addr = NP'(a); nwr_data = d;
        @(negedge clk);
        nwr_en = 1'b0;
    endtask

    // Dispatch; returns at the negedge where the first step is visible
    task automatic start(input int a);
        @(negedge clk);
        disp_valid = 1'b1; disp_addr = UA'(a);
        @(negedge clk);
        disp_valid = 1'b0;
    endtask

    // Walk vectors: apply flags, check outputs, move to next cycle
    task automatic walk(input int first, input int last);
        for (int i = first; i <= last; i++) begin
            logic [12:0] v;
            string tag;
            v = VEC[i];
            flags = v[12:11];
            #1;
            tag = v[0] ? "R5" : (v[10] ? "R3" : "R4");
            check_out(tag, v[10] ? pat(int'(v[9:1])) : '0, v[0]);
            @(negedge clk);
        end
        flags = 2'b00;
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst_n = 1'b0; disp_valid = 1'b0; disp_addr = '0; flags = '0;
        uwr_en = 1'b0; uwr_addr = '0; uwr_data = '0;
        nwr_en = 1'b0; nwr_addr = '0; nwr_data = '0;
        repeat (3) @(negedge clk);
        check_out("R1", '0, 1'b0);  // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < 16; i++) wr_nano(i, pat(i));
        wr_nano(511, pat(511));
        wr_micro(12'h010, mk_ptr(3));
        wr_micro(12'h011, mk_ptr(5));
        wr_micro(12'h012, mk_br(2'b00, 12'h020));
        wr_micro(12'h013, mk_ptr(7));
        wr_micro(12'h020, mk_ptr(3));
        wr_micro(12'h021, mk_br(2'b01, 12'h030));
        wr_micro(12'h022, mk_ptr(6));
        wr_micro(12'h023, mk_br(2'b10, 12'h040));
        wr_micro(12'h024, mk_ptr(9));
        wr_micro(12'h025, mk_br(2'b11, 0));
        wr_micro(12'h030, mk_ptr(8));
        wr_micro(12'h031, mk_br(2'b00, 12'h022));
        wr_micro(12'h040, mk_ptr(511));
        wr_micro(12'h041, mk_br(2'b11, 0));
        wr_micro(12'h3FF, mk_ptr(2));
        wr_micro(12'h000, mk_ptr(4));
        wr_micro(12'h001, mk_br(2'b11, 0));
        check_out("R1", '0, 1'b0);  // R1 idle before any dispatch

        // Table walk: R3 R4 R5 R6, R8 at entry 18, R9 in run C
        start(12'h010); walk(0, 10);
        start(12'h010); walk(11, 19);
        start(12'h3FF); walk(20, 22);

        // R5: parked after done, flags toggling
        for (int k = 0; k < 3; k++) begin
            flags = 2'(k + 1);
            #1;
            check_out("R5", '0, 1'b0);
            @(negedge clk);
        end
        flags = 2'b00;

        // R2 and R7: dispatch and writes strobed while running are ignored
        start(12'h010);
        #1;
        check_out("R2", pat(3), 1'b0);
        disp_valid = 1'b1; disp_addr = 10'h3FF;
        uwr_en = 1'b1; uwr_addr = 10'h025; uwr_data = mk_ptr(1);
        nwr_en = 1'b1; nwr_addr = 9'd9; nwr_data = '1;
        @(negedge clk);
        disp_valid = 1'b0; uwr_en = 1'b0; nwr_en = 1'b0;
        #1;
        check_out("R2", pat(5), 1'b0);
        @(negedge clk);
        walk(2, 10);  // R7: entry 9 still pattern 9, 0x025 still end

        // R10: replace a nano entry after reset and rerun
        wr_nano(3, ~pat(3));
        start(12'h010);
        #1;
        check_out("R10", ~pat(3), 1'b0);
        // R1: reset during a run returns to idle
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check_out("R1", '0, 1'b0);
        rst_n = 1'b1;
        wr_nano(3, pat(3));
        start(12'h010); walk(0, 10);

        // R8: both edge bits of the wide word
        wr_nano(12, {1'b1, 66'd0, 1'b1});
        wr_micro(12'h050, mk_ptr(12));
        wr_micro(12'h051, mk_br(2'b11, 0));
        start(12'h050);
        #1;
        check_out("R8", {1'b1, 66'd0, 1'b1}, 1'b0);
        @(negedge clk);
        #1;
        check_out("R5", '0, 1'b1);
        @(negedge clk);
        #1;
        check_out("R5", '0, 1'b0);

        report();
    end
endmodule